// File: doc/BRIEF.md
# Run-time partitioned integer vector lane

This block is a single 64-bit integer lane of a vector execution unit. Each issued operation chooses its element size, so the same 64-bit datapath acts as eight 8-bit, four 16-bit, two 32-bit or one 64-bit element. Every element is computed independently: no carry, borrow or shift-in bit crosses an element boundary.

Each operation carries an opcode, a signed/unsigned flag, the element size, an operand form, a saturation enable and an optional per-element write mask with the previous destination word. The operand form picks which of the two operands is replaced by a scalar that is copied into every element. The lane returns the result word and one overflow flag per element after a fixed two-cycle pipeline.

Top module: `valu_lane`

## Requirements
- R1: `elem_w` selects the element size: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Element i occupies bits [i*W +: W] of every word. No carry, borrow or shifted bit passes between elements.
- R2: Opcode 0 adds. Without saturation the sum wraps modulo 2^W. The element's flag is set when the exact sum lies outside the element's range: 0..2^W-1 when `signed_mode`=0, and -2^(W-1)..2^(W-1)-1 when `signed_mode`=1.
- R3: Opcode 1 computes a minus b per element. It wraps and sets the flag by the same range rule as R2. An unsigned borrow counts as overflow.
- R4: Opcode 2 multiplies. It returns the low W bits of each element product. The flag is set when the full product does not fit the element range.
- R5: With `sat_en`=1, an add, subtract or multiply whose exact result is out of range yields the nearest bound: maximum or minimum of the signed range, or 2^W-1 or 0 when unsigned. The flag is still set.
- R6: Opcode 3 is bitwise AND and opcode 4 is bitwise OR. They never set a flag and ignore `sat_en`.
- R7: Opcode 5 shifts left and opcode 6 shifts right. The amount is the b element modulo W. A right shift is arithmetic when `signed_mode`=1 and logical otherwise. Shifts never set a flag.
- R8: `opnd_form` 0 uses `vec_a` and `vec_b`. Form 1 replaces b by the broadcast scalar, and form 2 replaces a by it. The low W bits of `scalar_in` are copied into every element. Code 3 behaves as form 0.
- R9: With `mask_en`=1, an element i whose `elem_mask[i]` is 0 returns the matching element of `dst_old`, and its flag is 0. Mask bits at or above the element count have no effect. With `mask_en`=0 the mask is ignored.
- R10: Flag bits at or above the element count of the chosen size are always 0.
- R11: A word accepted with `in_valid`=1 produces `out_valid`=1 exactly two clock edges later. While `out_valid` is 0, `result` and `ovf_flags` keep their last values.
- R12: While `rst_n` is low at a clock edge, the lane clears `out_valid`, `result` and `ovf_flags` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 3 | Opcode: 0 add, 1 sub, 2 mul, 3 and, 4 or, 5 shift left, 6 shift right |
| signed_mode | input | 1 | 1 = signed elements |
| elem_w | input | 2 | Element size code (R1) |
| opnd_form | input | 2 | Operand form (R8) |
| sat_en | input | 1 | Clamp instead of wrap |
| mask_en | input | 1 | Apply `elem_mask` |
| elem_mask | input | 8 | Per-element write enable |
| vec_a | input | 64 | First vector operand |
| vec_b | input | 64 | Second vector operand |
| scalar_in | input | 64 | Scalar for broadcast forms |
| dst_old | input | 64 | Previous destination word for masked elements |
| out_valid | output | 1 | Result present |
| result | output | 64 | Result word |
| ovf_flags | output | 8 | Per-element overflow flags |

## Verification
Each result, flag set and valid bit is due two rising edges after its operation is sampled. Cycles without a valid output must leave the outputs unchanged. The bench drives on falling edges and keeps a two-entry history of expected values. At every falling edge it compares the outputs against the entry issued two falling edges earlier, so gaps in the input stream move the valid pattern by exactly two cycles. Random words are biased toward the range bounds. Directed words cover carries at element boundaries, shift amounts larger than the element, and mask bits beyond the element count.

// File: rtl/valu_pkg.sv
// Shared encodings for the partitioned vector lane.
// Assumes an 8-bit smallest element and four element sizes in power-of-two steps.
package valu_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MUL = 3'd2,
        OP_AND = 3'd3,
        OP_OR  = 3'd4,
        OP_SHL = 3'd5,
        OP_SHR = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        FORM_VV = 2'd0,
        FORM_VS = 2'd1,
        FORM_SV = 2'd2
    } form_e;
endpackage

// File: rtl/valu_operand_sel.sv
// Picks the two operand words for one operation.
// For the scalar forms it copies the low W bits of the scalar into every element
// at the requested size. It is purely combinational and assumes LANE_W = 8 << (NUM_W-1).
module valu_operand_sel #(
    parameter int LANE_W = 64,
    parameter int NUM_W  = 4,
    localparam int EW_BITS = $clog2(NUM_W)
) (
    input  logic [EW_BITS-1:0] elem_w,
    input  logic [1:0]         form,
    input  logic [LANE_W-1:0]  vec_a,
    input  logic [LANE_W-1:0]  vec_b,
    input  logic [LANE_W-1:0]  scalar,
    output logic [LANE_W-1:0]  opnd_a,
    output logic [LANE_W-1:0]  opnd_b
);
    import valu_pkg::*;

    logic [LANE_W-1:0] cand [NUM_W];
    logic [LANE_W-1:0] bcast;

    // One broadcast candidate for each element size
    for (genvar k = 0; k < NUM_W; k++) begin : g_bcast
        localparam int W = 8 << k;
        localparam int N = LANE_W / W;
        assign cand[k] = {N{scalar[W-1:0]}};
    end

    assign bcast = cand[elem_w];

    // Substitute the broadcast scalar for the operand the form names
    always_comb begin
        opnd_a = vec_a;
        opnd_b = vec_b;
        case (form)
            FORM_VS: opnd_b = bcast;
            FORM_SV: opnd_a = bcast;
            default: ;
        endcase
    end
endmodule

// File: rtl/valu_elem_slice.sv
// One element of width W: add, subtract, low-half multiply, AND, OR and shifts.
// It reports overflow against the signed or unsigned range and clamps when sat is set.
// The shift amount is b modulo W. Combinational; an unused opcode gives zero.
module valu_elem_slice #(
    parameter int W = 8,
    localparam int SH_W = $clog2(W)
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  valu_pkg::op_e    op,
    input  logic             sgn,
    input  logic             sat,
    output logic [W-1:0]     res,
    output logic             ovf
);
    import valu_pkg::*;

    localparam logic [W-1:0] MAX_U = {W{1'b1}};
    localparam logic [W-1:0] MAX_S = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_S = {1'b1, {(W-1){1'b0}}};

    logic [W:0]     ext_a, ext_b, sum, dif;
    logic [2*W-1:0] wa, wb, prod;
    logic [SH_W-1:0] sh;
    logic [W-1:0]   shr_v, raw, clamp;
    logic           of;

    // Operands extended by one bit so the top bit exposes carry or sign overflow
    assign ext_a = {sgn & a[W-1], a};
    assign ext_b = {sgn & b[W-1], b};
    assign sum   = ext_a + ext_b;
    assign dif   = ext_a - ext_b;

    // Double-width operands; the low 2W bits of the product are exact for both modes
    assign wa    = {{W{sgn & a[W-1]}}, a};
    assign wb    = {{W{sgn & b[W-1]}}, b};
    assign prod  = wa * wb;

    assign sh    = b[SH_W-1:0];
    assign shr_v = sgn ? W'($signed(a) >>> sh) : (a >> sh);

    // Raw result, range violation and bound for each opcode
    always_comb begin
        raw   = '0;
        of    = 1'b0;
        clamp = '0;
        case (op)
            OP_ADD: begin
                raw   = sum[W-1:0];
                of    = sgn ? (sum[W] ^ sum[W-1]) : sum[W];
                clamp = sgn ? (sum[W] ? MIN_S : MAX_S) : MAX_U;
            end
            OP_SUB: begin
                raw   = dif[W-1:0];
                of    = sgn ? (dif[W] ^ dif[W-1]) : dif[W];
                clamp = sgn ? (dif[W] ? MIN_S : MAX_S) : '0;
            end
            OP_MUL: begin
                raw   = prod[W-1:0];
                of    = sgn ? !((&prod[2*W-1:W-1]) || !(|prod[2*W-1:W-1]))
                            : (|prod[2*W-1:W]);
                clamp = sgn ? (prod[2*W-1] ? MIN_S : MAX_S) : MAX_U;
            end
            OP_AND:  raw = a & b;
            OP_OR:   raw = a | b;
            OP_SHL:  raw = a << sh;
            OP_SHR:  raw = shr_v;
            default: raw = '0;
        endcase
    end

    // Final value: clamp on a saturating range violation
    assign res = (sat && of) ? clamp : raw;
    assign ovf = of;
endmodule

// File: rtl/valu_width_bank.sv
// All elements of one fixed size W across the lane, with the write mask applied.
// A masked-off element passes the old destination element and a clear flag.
// Only the mask bits that exist at this size are connected.
module valu_width_bank #(
    parameter int LANE_W = 64,
    parameter int W      = 8,
    localparam int N     = LANE_W / W
) (
    input  logic [LANE_W-1:0] opnd_a,
    input  logic [LANE_W-1:0] opnd_b,
    input  logic [LANE_W-1:0] old_dst,
    input  valu_pkg::op_e     op,
    input  logic              sgn,
    input  logic              sat,
    input  logic              mask_en,
    input  logic [N-1:0]      mask_bits,
    output logic [LANE_W-1:0] res,
    output logic [N-1:0]      ovf
);
    // One slice per element, merged with the old value under the mask
    for (genvar e = 0; e < N; e++) begin : g_elem
        logic [W-1:0] r;
        logic         o;
        logic         keep;

        valu_elem_slice #(.W(W)) u_slice (
            .a   (opnd_a[e*W +: W]),
            .b   (opnd_b[e*W +: W]),
            .op  (op),
            .sgn (sgn),
            .sat (sat),
            .res (r),
            .ovf (o)
        );

        assign keep           = mask_en & ~mask_bits[e];
        assign res[e*W +: W]  = keep ? old_dst[e*W +: W] : r;
        assign ovf[e]         = o & ~keep;
    end
endmodule

// File: rtl/valu_lane.sv
// Partitioned integer vector lane with a two-stage pipeline.
// Stage 1 registers the selected operands and the controls. Stage 2 computes every
// element size in parallel, keeps the chosen one and registers it.
// Assumes LANE_W = 8 << (NUM_W-1). Outputs hold when no result is due.
module valu_lane #(
    parameter int LANE_W    = 64,
    parameter int NUM_W     = 4,
    localparam int MAX_ELEMS = LANE_W / 8,
    localparam int EW_BITS   = $clog2(NUM_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [2:0]            op_sel,
    input  logic                  signed_mode,
    input  logic [EW_BITS-1:0]    elem_w,
    input  logic [1:0]            opnd_form,
    input  logic                  sat_en,
    input  logic                  mask_en,
    input  logic [MAX_ELEMS-1:0]  elem_mask,
    input  logic [LANE_W-1:0]     vec_a,
    input  logic [LANE_W-1:0]     vec_b,
    input  logic [LANE_W-1:0]     scalar_in,
    input  logic [LANE_W-1:0]     dst_old,
    output logic                  out_valid,
    output logic [LANE_W-1:0]     result,
    output logic [MAX_ELEMS-1:0]  ovf_flags
);
    import valu_pkg::*;

    logic [LANE_W-1:0]    sel_a, sel_b;
    logic                 s1_valid, s1_sgn, s1_sat, s1_men;
    op_e                  s1_op;
    logic [EW_BITS-1:0]   s1_ew;
    logic [MAX_ELEMS-1:0] s1_mask;
    logic [LANE_W-1:0]    s1_a, s1_b, s1_old;
    logic [LANE_W-1:0]    bank_res [NUM_W];
    logic [MAX_ELEMS-1:0] bank_ovf [NUM_W];

    valu_operand_sel #(.LANE_W(LANE_W), .NUM_W(NUM_W)) u_opsel (
        .elem_w (elem_w),
        .form   (opnd_form),
        .vec_a  (vec_a),
        .vec_b  (vec_b),
        .scalar (scalar_in),
        .opnd_a (sel_a),
        .opnd_b (sel_b)
    );

    // Stage 1: capture the selected operands and the controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_op    <= OP_ADD;
            s1_sgn   <= 1'b0;
            s1_sat   <= 1'b0;
            s1_men   <= 1'b0;
            s1_ew    <= '0;
            s1_mask  <= '0;
            s1_a     <= '0;
            s1_b     <= '0;
            s1_old   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_op   <= op_e'(op_sel);
                s1_sgn  <= signed_mode;
                s1_sat  <= sat_en;
                s1_men  <= mask_en;
                s1_ew   <= elem_w;
                s1_mask <= elem_mask;
                s1_a    <= sel_a;
                s1_b    <= sel_b;
                s1_old  <= dst_old;
            end
        end
    end

    // One bank per element size; flags padded to the widest element count
    for (genvar k = 0; k < NUM_W; k++) begin : g_bank
        localparam int W = 8 << k;
        localparam int N = LANE_W / W;
        logic [N-1:0] fl;

        valu_width_bank #(.LANE_W(LANE_W), .W(W)) u_bank (
            .opnd_a    (s1_a),
            .opnd_b    (s1_b),
            .old_dst   (s1_old),
            .op        (s1_op),
            .sgn       (s1_sgn),
            .sat       (s1_sat),
            .mask_en   (s1_men),
            .mask_bits (s1_mask[N-1:0]),
            .res       (bank_res[k]),
            .ovf       (fl)
        );

        assign bank_ovf[k] = MAX_ELEMS'(fl);
    end

    // Stage 2: register the bank chosen by the element size
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ovf_flags <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                result    <= bank_res[s1_ew];
                ovf_flags <= bank_ovf[s1_ew];
            end
        end
    end
endmodule

// File: rtl/valu_lane_chk.sv
// Timing and flag properties of the lane. The checker runs its own two-stage copy
// of the controls so it can relate each output to the operation it belongs to.
module valu_lane_chk #(
    parameter int LANE_W    = 64,
    parameter int NUM_W     = 4,
    localparam int MAX_ELEMS = LANE_W / 8,
    localparam int EW_BITS   = $clog2(NUM_W)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [2:0]            op_sel,
    input logic [EW_BITS-1:0]    elem_w,
    input logic                  mask_en,
    input logic [MAX_ELEMS-1:0]  elem_mask,
    input logic                  out_valid,
    input logic [LANE_W-1:0]     result,
    input logic [MAX_ELEMS-1:0]  ovf_flags
);
    import valu_pkg::*;

    logic                 p1_v, p2_v, p1_men, p2_men;
    logic [2:0]           p1_op, p2_op;
    logic [EW_BITS-1:0]   p1_ew, p2_ew;
    logic [MAX_ELEMS-1:0] p1_mask, p2_mask, p2_live;
    logic                 p2_flagless;

    // Checker copy of the control pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p1_v <= 1'b0;  p2_v <= 1'b0;
            p1_men <= 1'b0; p2_men <= 1'b0;
            p1_op <= '0;   p2_op <= '0;
            p1_ew <= '0;   p2_ew <= '0;
            p1_mask <= '0; p2_mask <= '0;
        end else begin
            p1_v <= in_valid;  p2_v <= p1_v;
            p1_men <= mask_en; p2_men <= p1_men;
            p1_op <= op_sel;   p2_op <= p1_op;
            p1_ew <= elem_w;   p2_ew <= p1_ew;
            p1_mask <= elem_mask; p2_mask <= p1_mask;
        end
    end

    assign p2_live     = MAX_ELEMS'((MAX_ELEMS'(1) << (MAX_ELEMS >> p2_ew)) - 1);
    assign p2_flagless = (p2_op == OP_AND) || (p2_op == OP_OR) ||
                         (p2_op == OP_SHL) || (p2_op == OP_SHR);

    assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == p2_v);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(result) && $stable(ovf_flags)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && p2_flagless) |-> (ovf_flags == '0));

    assert_flag_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((ovf_flags & ~p2_live) == '0));

    assert_masked_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && p2_men) |-> ((ovf_flags & ~p2_mask) == '0));
endmodule

bind valu_lane valu_lane_chk #(.LANE_W(LANE_W), .NUM_W(NUM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .elem_w    (elem_w),
    .mask_en   (mask_en),
    .elem_mask (elem_mask),
    .out_valid (out_valid),
    .result    (result),
    .ovf_flags (ovf_flags)
);

// File: tb/tb_valu_lane.sv
// Self-checking bench: seeded random operations biased to range bounds, plus
// directed corner cases, compared with a behavioural model two cycles later.
module tb_valu_lane;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic        signed_mode = 1'b0;
    logic [1:0]  elem_w = '0;
    logic [1:0]  opnd_form = '0;
    logic        sat_en = 1'b0;
    logic        mask_en = 1'b0;
    logic [7:0]  elem_mask = '0;
    logic [63:0] vec_a = '0, vec_b = '0, scalar_in = '0, dst_old = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [7:0]  ovf_flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic        hv [2];
    logic [63:0] hr [2];
    logic [7:0]  hf [2];
    string       ht [2];
    logic [63:0] last_res = '0;
    logic [7:0]  last_flg = '0;

    always #4 clk = ~clk;

    valu_lane dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .signed_mode(signed_mode), .elem_w(elem_w), .opnd_form(opnd_form),
        .sat_en(sat_en), .mask_en(mask_en), .elem_mask(elem_mask),
        .vec_a(vec_a), .vec_b(vec_b), .scalar_in(scalar_in), .dst_old(dst_old),
        .out_valid(out_valid), .result(result), .ovf_flags(ovf_flags)
    );

    function automatic logic [127:0] get_el(input logic [63:0] x, input int i, input int w);
        logic [127:0] o = '0;
        for (int j = 0; j < w; j++) o[j] = x[i*w + j];
        return o;
    endfunction

    // Behavioural model written from the requirements
    function automatic void model(input logic [2:0] op, input bit sg, input logic [1:0] ew,
                                  input logic [1:0] fm, input bit sat, input bit men,
                                  input logic [7:0] mk, input logic [63:0] a, input logic [63:0] b,
                                  input logic [63:0] s, input logic [63:0] old,
                                  output logic [63:0] r, output logic [7:0] f);
        int w = 8 << ew;
        int n = 64 / w;
        logic [63:0] bc, oa, ob;
        r = '0;
        f = '0;
        for (int j = 0; j < 64; j++) bc[j] = s[j % w];
        oa = (fm == 2'd2) ? bc : a;
        ob = (fm == 2'd1) ? bc : b;
        for (int i = 0; i < n; i++) begin
            logic [127:0] ua, ub, e;
            logic signed [129:0] xa, xb, ex, lo, hi, one;
            bit of, arith;
            int sh;
            one = 1;
            ua = get_el(oa, i, w);
            ub = get_el(ob, i, w);
            xa = {2'b00, ua};
            xb = {2'b00, ub};
            if (sg && ua[w-1]) xa = xa - (one <<< w);
            if (sg && ub[w-1]) xb = xb - (one <<< w);
            lo = sg ? -(one <<< (w-1)) : 0;
            hi = sg ? (one <<< (w-1)) - 1 : (one <<< w) - 1;
            sh = int'(ub[5:0]) & (w - 1);
            of = 0; arith = 0; ex = 0; e = '0;
            case (op)
                3'd0: begin ex = xa + xb; arith = 1; end
                3'd1: begin ex = xa - xb; arith = 1; end
                3'd2: begin ex = xa * xb; arith = 1; end
                3'd3: e = ua & ub;
                3'd4: e = ua | ub;
                3'd5: e = ua << sh;
                3'd6: begin
                    if (sg) begin ex = xa >>> sh; e = ex[127:0]; end
                    else e = ua >> sh;
                end
                default: e = '0;
            endcase
            if (arith) begin
                of = (ex < lo) || (ex > hi);
                if (sat && of) ex = (ex < lo) ? lo : hi;
                e = ex[127:0];
            end
            if (men && !mk[i]) begin
                e = get_el(old, i, w);
                of = 0;
            end
            for (int j = 0; j < w; j++) r[i*w + j] = e[j];
            f[i] = of;
        end
    endfunction

    // One falling edge: check what is due now, then drive the next operation
    task automatic step(input bit v, input logic [2:0] op, input bit sg, input logic [1:0] ew,
                        input logic [1:0] fm, input bit sat, input bit men, input logic [7:0] mk,
                        input logic [63:0] a, input logic [63:0] b, input logic [63:0] s,
                        input logic [63:0] old, input string tag);
        logic [63:0] er;
        logic [7:0]  ef;
        @(negedge clk);
        n_chk++;
        if (hv[1]) begin
            if (out_valid !== 1'b1 || result !== hr[1] || ovf_flags !== hf[1]) begin
                n_bad++;
                $display("FAIL %s: valid=%0b result=%h flags=%h, expected valid=1 result=%h flags=%h",
                         ht[1], out_valid, result, ovf_flags, hr[1], hf[1]);
            end
            last_res = hr[1];
            last_flg = hf[1];
        end else if (out_valid !== 1'b0 || result !== last_res || ovf_flags !== last_flg) begin
            n_bad++;
            $display("FAIL R11: valid=%0b result=%h flags=%h, expected valid=0 result=%h flags=%h",
                     out_valid, result, ovf_flags, last_res, last_flg);
        end
        hv[1] = hv[0]; hr[1] = hr[0]; hf[1] = hf[0]; ht[1] = ht[0];
        model(op, sg, ew, fm, sat, men, mk, a, b, s, old, er, ef);
        hv[0] = v; hr[0] = er; hf[0] = ef; ht[0] = tag;
        in_valid = v; op_sel = op; signed_mode = sg; elem_w = ew; opnd_form = fm;
        sat_en = sat; mask_en = men; elem_mask = mk;
        vec_a = a; vec_b = b; scalar_in = s; dst_old = old;
    endtask

    function automatic logic [63:0] pick_word();
        case ($urandom % 8)
            0: return '1;
            1: return {8{8'h80}};
            2: return {8{8'h7f}};
            3: return {4{16'h8000}};
            4: return {2{32'h7fffffff}};
            5: return 64'h0;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3, 3'd4: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        hv[0] = 0; hv[1] = 0; hr[0] = '0; hr[1] = '0; hf[0] = '0; hf[1] = '0;
        ht[0] = "R12"; ht[1] = "R12";
        // Reset with junk on the inputs
        in_valid = 1'b1; vec_a = '1; vec_b = '1; op_sel = 3'd0;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || result !== '0 || ovf_flags !== '0) begin
            n_bad++;
            $display("FAIL R12: valid=%0b result=%h flags=%h, expected 0 0 0",
                     out_valid, result, ovf_flags);
        end

        // Directed corner cases
        step(1, 3'd0, 0, 2'd0, 2'd0, 0, 0, 8'h00, 64'h0000_0000_0000_00ff, 64'h1, 0, 0, "R1");
        step(1, 3'd0, 0, 2'd1, 2'd0, 0, 0, 8'h00, 64'h0000_ffff_0000_ffff, 64'h0000_0001_0000_0001, 0, 0, "R1");
        step(1, 3'd1, 0, 2'd2, 2'd0, 0, 0, 8'h00, 64'h1_0000_0000, 64'h1, 0, 0, "R3");
        step(1, 3'd0, 1, 2'd1, 2'd0, 1, 0, 8'h00, {4{16'h7fff}}, {4{16'h0001}}, 0, 0, "R5");
        step(1, 3'd1, 1, 2'd0, 2'd0, 1, 0, 8'h00, {8{8'h80}}, {8{8'h01}}, 0, 0, "R5");
        step(1, 3'd2, 0, 2'd2, 2'd0, 1, 0, 8'h00, {2{32'h0001_0000}}, {2{32'h0002_0000}}, 0, 0, "R5");
        step(1, 3'd1, 0, 2'd0, 2'd0, 1, 0, 8'h00, {8{8'h01}}, {8{8'h02}}, 0, 0, "R5");
        step(1, 3'd2, 1, 2'd1, 2'd0, 0, 0, 8'h00, {4{16'hffff}}, {4{16'hffff}}, 0, 0, "R4");
        step(1, 3'd2, 1, 2'd3, 2'd0, 0, 0, 8'h00, 64'h8000_0000_0000_0000, '1, 0, 0, "R4");
        step(1, 3'd6, 1, 2'd0, 2'd0, 0, 0, 8'h00, {8{8'h80}}, {8{8'd9}}, 0, 0, "R7");
        step(1, 3'd6, 0, 2'd0, 2'd0, 0, 0, 8'h00, {8{8'h80}}, {8{8'd9}}, 0, 0, "R7");
        step(1, 3'd5, 0, 2'd1, 2'd0, 0, 0, 8'h00, {4{16'h00ff}}, {4{16'd20}}, 0, 0, "R7");
        step(1, 3'd3, 0, 2'd0, 2'd0, 1, 0, 8'h00, '1, 64'h0f0f_0f0f_0f0f_0f0f, 0, 0, "R6");
        step(1, 3'd4, 1, 2'd2, 2'd0, 1, 0, 8'h00, 64'h8000_0000_0000_0000, 64'h1, 0, 0, "R6");
        step(1, 3'd1, 0, 2'd0, 2'd2, 0, 0, 8'h00, 0, 64'h0102_0304_0506_0708, 64'hab05, 0, "R8");
        step(1, 3'd5, 0, 2'd1, 2'd1, 0, 0, 8'h00, 64'h0001_0002_0003_0004, 0, 64'h1234_0003, 0, "R8");
        step(1, 3'd0, 0, 2'd2, 2'd3, 0, 0, 8'h00, 64'h5, 64'h7, 64'hffff, 0, "R8");
        step(1, 3'd0, 0, 2'd0, 2'd0, 0, 1, 8'ha5, '1, {8{8'h01}}, 0, 64'h1122_3344_5566_7788, "R9");
        step(1, 3'd0, 0, 2'd3, 2'd0, 0, 1, 8'hfe, '1, 64'h1, 0, 64'hdead_beef_0000_1111, "R9");
        step(1, 3'd0, 0, 2'd1, 2'd0, 0, 0, 8'h00, '1, '1, 0, 64'h5555, "R9");
        step(1, 3'd0, 1, 2'd3, 2'd0, 0, 0, 8'h00, 64'h7fff_ffff_ffff_ffff, 64'h1, 0, 0, "R10");
        step(0, 3'd0, 0, 2'd0, 2'd0, 0, 0, 8'h00, '1, '1, 0, 0, "R11");
        step(0, 3'd0, 0, 2'd0, 2'd0, 0, 0, 8'h00, '1, '1, 0, 0, "R11");
        step(0, 3'd0, 0, 2'd0, 2'd0, 0, 0, 8'h00, 0, 0, 0, 0, "R11");

        // Seeded random stream with idle gaps
        for (int k = 0; k < 4000; k++) begin
            logic [2:0] op;
            bit v;
            op = 3'($urandom % 7);
            v  = ($urandom % 5) != 0;
            step(v, op, 1'($urandom), 2'($urandom), 2'($urandom % 3), 1'($urandom),
                 ($urandom % 4) == 0, 8'($urandom), pick_word(), pick_word(),
                 pick_word(), {$urandom, $urandom}, v ? op_tag(op) : "R11");
        end

        // Drain the pipeline
        for (int k = 0; k < 3; k++)
            step(0, 3'd0, 0, 2'd0, 2'd0, 0, 0, 8'h00, 0, 0, 0, 0, "R11");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule